// File: doc/BRIEF.md
# Host-Side Comms Link Register Card

This block is the host end of a byte-wide parallel comms link to a cartridge. The host sees two registers on a simple synchronous register bus: a data port at the base address and a status port two locations above it. A host write to the data port latches an outgoing byte and raises the strobe toward the far end; while the strobe is up, the block drives that byte onto the link data lines. The far end answers with an acknowledge pulse that drops the strobe, places its reply byte on the link, and marks a reply as available.

The host's loop is: write a byte, poll the status port while bit 0 reads 1, then read the data port for the reply. The acknowledge pulse is handled entirely in hardware, since it is far too short for software to catch. A small link state machine has three states. `LS_IDLE` means the bus is released and no byte is on offer. `LS_DRIVE` means the strobe is high and the latch is on the bus. `LS_ACK` means the acknowledge is high and the reply is being captured. The transitions are:

- `IDLE->DRIVE` on a data write.
- `IDLE->ACK` and `DRIVE->ACK` when the acknowledge is seen.
- `ACK->ACK` while it stays high.
- `ACK->DRIVE` when it falls with a write pending from during the pulse.
- `ACK->IDLE` when it falls with nothing pending.

Top module: `link_card`

## Requirements
- R1: Only address BASE_ADDR (data port) and BASE_ADDR+2 (status port) respond. Reads at any other address return 0, and writes at any other address, or to the status port, change nothing.
- R2: A data port write with the acknowledge low stores `bus_wdata` in the outgoing latch, and `link_stb` is 1 from the following clock edge.
- R3: While `link_stb` is 1, `link_oe` is 1 and `link_dout` equals the outgoing latch. Otherwise `link_oe` is 0 and `link_dout` is 0.
- R4: `link_ack` sampled high at a clock edge makes `link_stb` 0 from that edge on, for as long as the acknowledge stays high.
- R5: The reply register loads `link_din` at every clock edge where `link_ack` is high, so it holds the byte present in the last cycle of the pulse.
- R6: At the first clock edge where `link_ack` is low after being high, the reply-available flag is set. From then on status bit 0 reads 0.
- R7: A data port read returns the reply register and clears the reply-available flag at that edge, so status bit 0 reads 1 again. If the acknowledge falls in the same cycle, the flag stays set.
- R8: A data port write while `link_stb` is 1 replaces the latch contents, and `link_stb` stays 1.
- R9: A data port write while the acknowledge is high updates the latch but keeps `link_stb` low. `link_stb` rises at the edge where the acknowledge is first seen low.
- R10: Status bit 1 reads the current `link_stb`, status bit 0 reads the inverse of the reply-available flag, and bits 7 to 2 read 0.
- R11: After reset, `link_stb` and `link_oe` are 0, the reply register is 0, and the status port reads 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Host register address |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wdata | input | DATA_W | Host write data |
| bus_rdata | output | DATA_W | Host read data, valid in the cycle of `bus_rd` |
| link_dout | output | DATA_W | Outgoing byte toward the link |
| link_oe | output | 1 | Output enable for `link_dout` onto the shared link lines |
| link_din | input | DATA_W | Link data lines as seen by the card |
| link_stb | output | 1 | Strobe toward the far end: a byte is on offer |
| link_ack | input | 1 | Acknowledge pulse from the far end |

## Verification
The bench builds the block with its default base of 0x330, a 10-bit address and an 8-bit byte. This places the data port at 0x330 and the status port at 0x332. With these values, neighbouring addresses such as 0x331 and 0x334 can be used to test that nothing else decodes. The byte width makes the fixed status bit layout and the full reply value visible to the host. These settings also allow a test where the acknowledge pulse carries two different bytes in successive cycles, a write issued during the pulse, and a reply read in the same cycle as the falling acknowledge.

// File: rtl/link_card_pkg.sv
package link_card_pkg;

    typedef enum logic [1:0] {
        LS_IDLE  = 2'd0,
        LS_DRIVE = 2'd1,
        LS_ACK   = 2'd2
    } link_state_t;

    localparam int unsigned DATA_PORT_OFS   = 0;
    localparam int unsigned STATUS_PORT_OFS = 2;
    localparam int unsigned ST_NOREPLY_BIT  = 0;
    localparam int unsigned ST_STROBE_BIT   = 1;

endpackage

// File: rtl/link_host_decode.sv
module link_host_decode
    import link_card_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned DATA_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h330
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] reply_q,
    input  logic              reply_avail,
    input  logic              stb,
    output logic              data_wr,
    output logic              data_rd,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] DATA_ADDR   = BASE_ADDR + ADDR_W'(DATA_PORT_OFS);
    localparam logic [ADDR_W-1:0] STATUS_ADDR = BASE_ADDR + ADDR_W'(STATUS_PORT_OFS);

    logic hit_data;
    logic hit_status;
    logic [DATA_W-1:0] status_word;

    assign hit_data   = (bus_addr == DATA_ADDR);
    assign hit_status = (bus_addr == STATUS_ADDR);
    assign data_wr    = bus_wr & hit_data;
    assign data_rd    = bus_rd & hit_data;

    always_comb begin
        status_word = '0;
        status_word[ST_NOREPLY_BIT] = ~reply_avail;
        status_word[ST_STROBE_BIT]  = stb;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_data) begin
                bus_rdata = reply_q;
            end else if (hit_status) begin
                bus_rdata = status_word;
            end
        end
    end

endmodule

// File: rtl/link_strobe_fsm.sv
module link_strobe_fsm
    import link_card_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack,
    output logic              stb,
    output logic              oe,
    output logic [DATA_W-1:0] dout
);

    link_state_t state_q, state_n;
    logic        pend_q, pend_n;
    logic [DATA_W-1:0] out_latch_q;

    // Next-state logic
    always_comb begin
        state_n = state_q;
        pend_n  = 1'b0;
        unique case (state_q)
            LS_IDLE: begin
                if (ack) begin
                    state_n = LS_ACK;
                    pend_n  = data_wr;
                end else if (data_wr) begin
                    state_n = LS_DRIVE;
                end
            end
            LS_DRIVE: begin
                if (ack) begin
                    state_n = LS_ACK;
                    pend_n  = data_wr;
                end
            end
            LS_ACK: begin
                if (ack) begin
                    state_n = LS_ACK;
                    pend_n  = pend_q | data_wr;
                end else if (pend_q | data_wr) begin
                    state_n = LS_DRIVE;
                end else begin
                    state_n = LS_IDLE;
                end
            end
            default: begin
                state_n = LS_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LS_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            pend_q  <= pend_n;
        end
    end

    // Outgoing latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_latch_q <= '0;
        end else if (data_wr) begin
            out_latch_q <= wdata;
        end
    end

    // Outputs
    always_comb begin
        stb  = 1'b0;
        oe   = 1'b0;
        dout = '0;
        unique case (state_q)
            LS_DRIVE: begin
                stb  = 1'b1;
                oe   = 1'b1;
                dout = out_latch_q;
            end
            LS_IDLE, LS_ACK: begin
                stb = 1'b0;
            end
            default: begin
                stb = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/link_reply_capture.sv
module link_reply_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack,
    input  logic [DATA_W-1:0] din,
    input  logic              data_rd,
    output logic [DATA_W-1:0] reply_q,
    output logic              reply_avail
);

    logic ack_q;
    logic ack_end;

    assign ack_end = ack_q & ~ack;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= ack;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reply_q <= '0;
        end else if (ack) begin
            reply_q <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reply_avail <= 1'b0;
        end else if (ack_end) begin
            reply_avail <= 1'b1;
        end else if (data_rd) begin
            reply_avail <= 1'b0;
        end
    end

endmodule

// File: rtl/link_card.sv
module link_card
    import link_card_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned DATA_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h330
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] link_dout,
    output logic              link_oe,
    input  logic [DATA_W-1:0] link_din,
    output logic              link_stb,
    input  logic              link_ack
);

    logic data_wr;
    logic data_rd;
    logic [DATA_W-1:0] reply_q;
    logic reply_avail;

    link_host_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .reply_q     (reply_q),
        .reply_avail (reply_avail),
        .stb         (link_stb),
        .data_wr     (data_wr),
        .data_rd     (data_rd),
        .bus_rdata   (bus_rdata)
    );

    link_strobe_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_wr (data_wr),
        .wdata   (bus_wdata),
        .ack     (link_ack),
        .stb     (link_stb),
        .oe      (link_oe),
        .dout    (link_dout)
    );

    link_reply_capture #(
        .DATA_W (DATA_W)
    ) u_reply (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack         (link_ack),
        .din         (link_din),
        .data_rd     (data_rd),
        .reply_q     (reply_q),
        .reply_avail (reply_avail)
    );

endmodule

// File: rtl/link_card_chk.sv
module link_card_chk #(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned DATA_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h330
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] link_dout,
    input logic              link_stb,
    input logic              link_ack,
    input logic              reply_avail
);

    logic wr_data_port;
    logic rd_data_port;
    assign wr_data_port = bus_wr && (bus_addr == BASE_ADDR);
    assign rd_data_port = bus_rd && (bus_addr == BASE_ADDR);

    a_r2_write_raises_stb: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data_port && !link_ack) |=> link_stb);

    a_r3_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
        !link_stb |-> (link_dout == '0));

    a_r4_ack_drops_stb: assert property (@(posedge clk) disable iff (!rst_n)
        link_ack |=> !link_stb);

    a_r6_ack_end_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(link_ack) && !link_ack) |=> reply_avail);

    a_r7_read_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_port && !($past(link_ack) && !link_ack)) |=> !reply_avail);

    a_r8_rewrite_keeps_stb: assert property (@(posedge clk) disable iff (!rst_n)
        (link_stb && wr_data_port && !link_ack) |=>
            (link_stb && link_dout == $past(bus_wdata)));

endmodule

bind link_card link_card_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .link_dout   (link_dout),
    .link_stb    (link_stb),
    .link_ack    (link_ack),
    .reply_avail (reply_avail)
);

// File: tb/link_card_test.sv
module link_card_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 8;
    localparam logic [ADDR_W-1:0] BASE = 10'h330;
    localparam logic [ADDR_W-1:0] STAT = 10'h332;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic bus_wr = 1'b0;
    logic bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [DATA_W-1:0] link_dout;
    logic link_oe;
    logic [DATA_W-1:0] link_din = '0;
    logic link_stb;
    logic link_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [DATA_W-1:0] val;
        string             req;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    link_card #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .link_dout(link_dout), .link_oe(link_oe), .link_din(link_din),
        .link_stb(link_stb), .link_ack(link_ack)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compares every host read against the scoreboard
    always @(negedge clk) begin
        if (bus_rd) begin
            if (exp_q.size() == 0) begin
                check("scoreboard", 32'(bus_rdata), 32'hDEAD);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, 32'(bus_rdata), 32'(e.val));
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Driver: sets up one access for the next clock edge
    task automatic set_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    endtask

    task automatic set_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string req);
        exp_t x;
        x.val = e; x.req = req;
        exp_q.push_back(x);
        bus_addr = a; bus_rd = 1'b1;
    endtask

    task automatic idle_bus();
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic host_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        set_write(a, d); tick(); idle_bus();
    endtask

    task automatic host_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string req);
        set_read(a, e, req); tick(); idle_bus();
    endtask

    task automatic finish_run();
        check("scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R11 reset state
        check("R11 stb", 32'(link_stb), 0);
        check("R11 oe", 32'(link_oe), 0);
        host_read(STAT, 8'h01, "R11 status");
        host_read(BASE, 8'h00, "R11 reply");

        // R2, R3, R10: write raises strobe and drives the bus
        host_write(BASE, 8'hA5);
        check("R2 stb", 32'(link_stb), 1);
        check("R3 oe", 32'(link_oe), 1);
        check("R3 dout", 32'(link_dout), 32'hA5);
        host_read(STAT, 8'h03, "R10 status with stb");

        // R8: rewrite while strobe high
        host_write(BASE, 8'h3C);
        check("R8 stb", 32'(link_stb), 1);
        check("R8 dout", 32'(link_dout), 32'h3C);

        // R4, R5: acknowledge pulse with two bytes
        link_ack = 1'b1; link_din = 8'h11; tick();
        check("R4 stb low", 32'(link_stb), 0);
        check("R3 oe low", 32'(link_oe), 0);
        check("R3 dout zero", 32'(link_dout), 0);
        host_read(STAT, 8'h01, "R6 no flag during ack");
        link_din = 8'h77; tick();
        link_ack = 1'b0; link_din = 8'hEE; tick();
        host_read(STAT, 8'h00, "R6 flag set");
        host_read(BASE, 8'h77, "R5 last ack byte");
        host_read(STAT, 8'h01, "R7 flag cleared");

        // R1: other addresses
        host_write(BASE + 10'd1, 8'hFF);
        check("R1 stb unmoved", 32'(link_stb), 0);
        host_write(STAT, 8'hFF);
        check("R1 status write ignored", 32'(link_stb), 0);
        host_read(BASE + 10'd4, 8'h00, "R1 unmapped read");
        host_read(STAT, 8'h01, "R1 status unchanged");

        // R9: write during acknowledge
        link_ack = 1'b1; link_din = 8'h42; tick();
        host_write(BASE, 8'h99);
        check("R9 stb held low", 32'(link_stb), 0);
        link_ack = 1'b0; tick();
        check("R9 stb rises", 32'(link_stb), 1);
        check("R9 dout", 32'(link_dout), 32'h99);
        host_read(BASE, 8'h42, "R7 reply read");
        host_read(STAT, 8'h03, "R7 flag cleared, R10 stb");

        // R7: read in the same cycle as acknowledge end
        link_ack = 1'b1; link_din = 8'h5A; tick();
        link_ack = 1'b0;
        host_read(BASE, 8'h5A, "R7 read at ack end");
        host_read(STAT, 8'h00, "R7 set wins over clear");
        host_read(BASE, 8'h5A, "R7 second read");
        host_read(STAT, 8'h01, "R7 cleared after read");

        repeat (2) tick();
        finish_run();
    end

endmodule